// File: doc/BRIEF.md
# Fault Outcome Classification Monitor

This block watches a processor under test for the length of one fault-injection run and places the run into exactly one outcome class. A run opens on a start strobe. While the run is open, the monitor watches five trap strobes, a halt indication and an internal cycle watchdog. The run closes when the processor signals completion, when it halts, or when the watchdog expires. At that point the monitor emits a 3-bit class code together with a one-cycle valid pulse.

A clean completion with output equal to the golden result is masked. A clean completion with wrong output is silent. A halt or watchdog expiry with no earlier trap is stopped. Otherwise the run takes the class of the trap that arrived first. When several events arrive in the same cycle, a fixed priority picks one. A bank of saturating per-class counters tallies outcomes across a campaign. The host reads the counters one at a time through a select input and can zero them all with a clear input.

Top module: `fault_outcome_monitor`

## Requirements
- R1: After reset, `cls_valid` is 0, no run is open, and every counter reads 0.
- R2: A run that closes on `run_done` with `out_match` high and no earlier or same-cycle event reports class 0 (masked).
- R3: A run that closes on `run_done` with `out_match` low and no event reports class 1 (silent).
- R4: Trap strobe bit i reports class i+2, whatever the value of `out_match`: bit 0 data store error = 2, bit 1 data access = 3, bit 2 misaligned address = 4, bit 3 illegal instruction = 5, bit 4 instruction access = 6.
- R5: The first event of a run fixes its class. A later trap, halt, watchdog expiry or output mismatch does not change it.
- R6: Several events in the same cycle resolve by encoding from the top down: stopped (halt or expiry) first, then class 6, then 5, down to 2.
- R7: `halted` during a run closes the run in that cycle. With no earlier event, the run reports class 7 (stopped).
- R8: The watchdog counts the run's cycles, with the first cycle after the accepted start being cycle 0. If the run is still open in cycle `wd_limit`, it closes there as stopped, even when `run_done` is also high in that cycle.
- R9: Each run yields exactly one `cls_valid` pulse, one cycle long, in the cycle after the closing cycle. Strobes while no run is open are ignored, and `run_start` during an open run neither restarts it nor its watchdog.
- R10: Each result adds one to the counter of its class. `rd_count` shows the counter chosen by `rd_sel` (class code) in the cycle after the closing cycle.
- R11: A counter at its all-ones value stays there on further results.
- R12: `cnt_clr` zeros all counters at the next edge and wins over a same-cycle increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_start | input | 1 | Opens a run when none is open |
| run_done | input | 1 | Processor reports run complete |
| out_match | input | 1 | Output equals golden result (sampled at completion) |
| trap_strobe | input | 5 | Per-type trap strobes, bit i maps to class i+2 |
| halted | input | 1 | Processor halted |
| wd_limit | input | WD_W | Watchdog limit in cycles, held stable during a run |
| cnt_clr | input | 1 | Zero all outcome counters |
| rd_sel | input | 3 | Class whose counter appears on rd_count |
| cls_out | output | 3 | Outcome class code |
| cls_valid | output | 1 | One-cycle pulse marking cls_out valid |
| rd_count | output | CNT_W | Selected counter value |

## Verification
The embedded assertions check, on every cycle: that the valid pulse lasts a single cycle and never overlaps an open run, that a latched first event stays frozen for the rest of the run, that the watchdog count never exceeds its limit, and that counters never fall except on clear, hold at saturation, and read zero after a clear. The class-to-stimulus mapping needs the bench's scenarios to be shown. This covers the masked/silent split, the trap bit encoding, same-cycle priority, first-arrival ordering across cycles, the exact watchdog boundary cycle, restart-while-open and strobes while idle. The bench compares these, and the counter tallies, against its own model.

// File: rtl/fom_pkg.sv
// Shared types and helpers for the fault outcome monitor.
// Assumes class codes are fixed: trap bit i maps to class i+2.
package fom_pkg;
    localparam int TRAP_N  = 5;
    localparam int NUM_CLS = 8;
    localparam int CLS_W   = $clog2(NUM_CLS);

    typedef enum logic [CLS_W-1:0] {
        CLS_MASKED  = 3'd0,
        CLS_SILENT  = 3'd1,
        CLS_STORE   = 3'd2,
        CLS_DACCESS = 3'd3,
        CLS_ALIGN   = 3'd4,
        CLS_ILLEGAL = 3'd5,
        CLS_IACCESS = 3'd6,
        CLS_STOPPED = 3'd7
    } outcome_e;

    // Highest set trap bit wins; returns its class code.
    function automatic logic [CLS_W-1:0] trap_to_cls(input logic [TRAP_N-1:0] v);
        logic [CLS_W-1:0] c;
        c = CLS_STORE;
        for (int i = 0; i < TRAP_N; i++) begin
            if (v[i]) c = CLS_W'(i + 2);
        end
        return c;
    endfunction
endpackage

// File: rtl/fom_watchdog.sv
// Run watchdog: counts cycles of an open run and flags expiry when the
// count reaches the programmed limit. Assumes limit is held stable
// while a run is open.
module fom_watchdog #(
    parameter int WD_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            active,
    input  logic [WD_W-1:0] limit,
    output logic            expired
);
    localparam logic [WD_W-1:0] WD_MAX = '1;

    logic [WD_W-1:0] cnt;

    // Cycle counter: cleared on accepted start, advances while open.
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt <= '0;
        else if (start)                    cnt <= '0;
        else if (active && cnt != WD_MAX)  cnt <= cnt + 1'b1;
    end

    // Expiry flag for the current cycle.
    always_comb expired = active && (cnt == limit);

    // R8: an open run never sees its count pass the limit.
    p_wd_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt <= limit));
endmodule

// File: rtl/fom_event_latch.sv
// First-event latch: resolves same-cycle events by fixed priority and
// keeps the first resolved event for the rest of the run.
// Assumes inputs are already gated to the open-run window.
module fom_event_latch
    import fom_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [TRAP_N-1:0] traps,
    input  logic              stop_evt,
    output logic              now_hit,
    output logic [CLS_W-1:0]  now_cls,
    output logic              have_evt,
    output logic [CLS_W-1:0]  evt_cls
);
    // Same-cycle priority: stopped above every trap, traps top-down.
    always_comb begin
        now_hit = stop_evt || (|traps);
        now_cls = stop_evt ? CLS_STOPPED : trap_to_cls(traps);
    end

    // Capture the first event of the run and hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_evt <= 1'b0;
            evt_cls  <= CLS_MASKED;
        end else if (clear) begin
            have_evt <= 1'b0;
        end else if (!have_evt && now_hit) begin
            have_evt <= 1'b1;
            evt_cls  <= now_cls;
        end
    end

    // R5: once captured, the first event is frozen until the next run.
    p_first_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (have_evt && !clear) |=> (have_evt && $stable(evt_cls)));
endmodule

// File: rtl/fom_counter_bank.sv
// Per-class saturating outcome counters with a global clear and a
// single read port selected by class code.
module fom_counter_bank
    import fom_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [CLS_W-1:0] inc_cls,
    input  logic [CLS_W-1:0] rd_sel,
    output logic [CNT_W-1:0] rd_data
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt [NUM_CLS];

    for (genvar g = 0; g < NUM_CLS; g++) begin : g_cnt
        // One counter: clear wins, else saturating increment on its class.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                cnt[g] <= '0;
            else if (inc && inc_cls == CLS_W'(g) && cnt[g] != CNT_MAX)
                cnt[g] <= cnt[g] + 1'b1;
        end

        // R10: counters only rise, except on clear.
        p_monotonic_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(clr) |-> (cnt[g] >= $past(cnt[g])));
        // R11: saturated counters hold.
        p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt[g] == CNT_MAX && !clr) |=> (cnt[g] == CNT_MAX));
        // R12: clear empties every counter.
        p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> (cnt[g] == '0));
    end

    // Read mux.
    always_comb rd_data = cnt[rd_sel];
endmodule

// File: rtl/fault_outcome_monitor.sv
// Fault outcome monitor top: opens a run on start, gates events to the
// run window, closes on completion, halt or watchdog expiry, and emits
// one class code per run plus per-class tallies.
// Assumes out_match is valid in the cycle run_done is high.
module fault_outcome_monitor
    import fom_pkg::*;
#(
    parameter int WD_W  = 16,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_start,
    input  logic             run_done,
    input  logic             out_match,
    input  logic [4:0]       trap_strobe,
    input  logic             halted,
    input  logic [WD_W-1:0]  wd_limit,
    input  logic             cnt_clr,
    input  logic [2:0]       rd_sel,
    output logic [2:0]       cls_out,
    output logic             cls_valid,
    output logic [CNT_W-1:0] rd_count
);
    logic              active;
    logic              start_acc;
    logic              expired;
    logic              stop_now;
    logic [TRAP_N-1:0] trap_now;
    logic              now_hit;
    logic [CLS_W-1:0]  now_cls;
    logic              have_evt;
    logic [CLS_W-1:0]  evt_cls;
    logic              term;
    logic [CLS_W-1:0]  final_cls;
    logic              vld_q;
    logic [CLS_W-1:0]  cls_q;

    // Gate events to the open-run window and decide the closing cycle.
    always_comb begin
        start_acc = run_start && !active;
        trap_now  = active ? trap_strobe : '0;
        stop_now  = active && (halted || expired);
        term      = active && (run_done || stop_now);
    end

    // Outcome resolution: first event, else same-cycle event, else output.
    always_comb begin
        if (have_evt)     final_cls = evt_cls;
        else if (now_hit) final_cls = now_cls;
        else              final_cls = out_match ? CLS_MASKED : CLS_SILENT;
    end

    // Run window flag.
    always_ff @(posedge clk) begin
        if (!rst_n)         active <= 1'b0;
        else if (start_acc) active <= 1'b1;
        else if (term)      active <= 1'b0;
    end

    // Registered result and its one-cycle valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            cls_q <= CLS_MASKED;
        end else begin
            vld_q <= term;
            if (term) cls_q <= final_cls;
        end
    end

    fom_watchdog #(.WD_W(WD_W)) i_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_acc),
        .active  (active),
        .limit   (wd_limit),
        .expired (expired)
    );

    fom_event_latch i_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start_acc),
        .traps    (trap_now),
        .stop_evt (stop_now),
        .now_hit  (now_hit),
        .now_cls  (now_cls),
        .have_evt (have_evt),
        .evt_cls  (evt_cls)
    );

    fom_counter_bank #(.CNT_W(CNT_W)) i_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .inc     (term),
        .inc_cls (final_cls),
        .rd_sel  (rd_sel),
        .rd_data (rd_count)
    );

    always_comb begin
        cls_out   = cls_q;
        cls_valid = vld_q;
    end

    // R9: the valid pulse lasts one cycle.
    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |=> !vld_q);
    // R9: a result is only presented once its run has closed.
    p_closed_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> !active);
    // R7: a halt in an open run always closes it at that edge.
    p_halt_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && halted) |=> (vld_q && !active));
endmodule

// File: tb/test_fault_outcome_monitor.sv
module test_fault_outcome_monitor;
    localparam int WD_W  = 8;
    localparam int CNT_W = 5;
    localparam int SAT   = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             run_start = 1'b0;
    logic             run_done = 1'b0;
    logic             out_match = 1'b0;
    logic [4:0]       trap_strobe = '0;
    logic             halted = 1'b0;
    logic [WD_W-1:0]  wd_limit = '0;
    logic             cnt_clr = 1'b0;
    logic [2:0]       rd_sel = '0;
    logic [2:0]       cls_out;
    logic             cls_valid;
    logic [CNT_W-1:0] rd_count;

    int total = 0;
    int bad   = 0;
    int exp_cnt [8];
    int cyc = 0;
    bit done_flag = 1'b0;

    fault_outcome_monitor #(.WD_W(WD_W), .CNT_W(CNT_W)) i_fault_outcome_monitor (
        .clk(clk), .rst_n(rst_n), .run_start(run_start), .run_done(run_done),
        .out_match(out_match), .trap_strobe(trap_strobe), .halted(halted),
        .wd_limit(wd_limit), .cnt_clr(cnt_clr), .rd_sel(rd_sel),
        .cls_out(cls_out), .cls_valid(cls_valid), .rd_count(rd_count)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done_flag) begin
            done_flag = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: act=%0d exp=<150000 cycles", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int pri(input logic [4:0] v);
        int c = -1;
        for (int i = 0; i < 5; i++) if (v[i]) c = i + 2;
        return c;
    endfunction

    task automatic check_counters(input string req);
        for (int k = 0; k < 8; k++) begin
            rd_sel = 3'(k);
            #1;
            chk(req, int'(rd_count), exp_cnt[k]);
        end
    endtask

    // One run; cycle j counts from the first cycle after the start edge.
    task automatic do_run(input int len, input int limit, input int trap_cyc,
                          input logic [4:0] trapv, input int halt_cyc,
                          input bit match, input int restart_cyc,
                          input bit clr_term, input string req);
        int first = -1;
        int res = 0;
        wd_limit = WD_W'(limit);
        @(negedge clk); run_start = 1'b1;
        @(negedge clk); run_start = 1'b0;
        for (int j = 0; j < 300; j++) begin
            bit stop, dn, term;
            logic [4:0] tv;
            stop = (j == halt_cyc) || (j == limit);
            tv   = (j == trap_cyc) ? trapv : 5'd0;
            dn   = (j == len);
            halted = (j == halt_cyc);
            trap_strobe = tv;
            run_done = dn;
            out_match = match;
            run_start = (j == restart_cyc);
            if (first < 0) begin
                if (stop) first = 7;
                else if (tv != 0) first = pri(tv);
            end
            term = stop || dn;
            cnt_clr = term && clr_term;
            if (term) res = (first >= 0) ? first : (match ? 0 : 1);
            @(negedge clk);
            halted = 0; trap_strobe = 0; run_done = 0; run_start = 0; cnt_clr = 0;
            if (term) break;
        end
        if (clr_term) foreach (exp_cnt[k]) exp_cnt[k] = 0;
        else if (exp_cnt[res] < SAT) exp_cnt[res]++;
        chk({req, " valid"}, int'(cls_valid), 1);
        chk({req, " class"}, int'(cls_out), res);
        rd_sel = 3'(res);
        #1;
        chk({req, " R10 count"}, int'(rd_count), exp_cnt[res]);
        @(negedge clk);
        chk({req, " R9 pulse end"}, int'(cls_valid), 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        foreach (exp_cnt[k]) exp_cnt[k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 valid after reset", int'(cls_valid), 0);
        check_counters("R1 counters after reset");

        // Directed cases.
        do_run(2, 10, -1, 5'd0, -1, 1'b1, -1, 1'b0, "R2 masked");
        do_run(3, 10, -1, 5'd0, -1, 1'b0, -1, 1'b0, "R3 silent");
        for (int b = 0; b < 5; b++)
            do_run(4, 10, 1, 5'(1 << b), -1, 1'b1, -1, 1'b0, "R4 trap bit");
        do_run(5, 10, 1, 5'b00001, 3, 1'b0, -1, 1'b0, "R5 first trap beats halt");
        do_run(6, 10, 2, 5'b00010, -1, 1'b1, -1, 1'b0, "R5 trap beats match");
        do_run(6, 10, 1, 5'b10101, 1, 1'b1, -1, 1'b0, "R6 halt beats traps");
        do_run(6, 10, 1, 5'b01110, -1, 1'b1, -1, 1'b0, "R6 trap priority");
        do_run(9, 10, -1, 5'd0, 2, 1'b1, -1, 1'b0, "R7 halted");
        do_run(3, 4, -1, 5'd0, -1, 1'b1, -1, 1'b0, "R8 done before limit");
        do_run(4, 4, -1, 5'd0, -1, 1'b1, -1, 1'b0, "R8 done at limit");
        do_run(0, 0, -1, 5'd0, -1, 1'b1, -1, 1'b0, "R8 zero limit");
        do_run(8, 5, -1, 5'd0, -1, 1'b1, 3, 1'b0, "R9 restart ignored");

        // R9: strobes while idle change nothing.
        @(negedge clk);
        trap_strobe = 5'b11111; halted = 1'b1; run_done = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk("R9 idle strobes no result", int'(cls_valid), 0);
        end
        trap_strobe = 0; halted = 0; run_done = 0;
        check_counters("R9 idle strobes no count");

        // R12: clear wins over same-cycle increment.
        do_run(1, 10, -1, 5'd0, -1, 1'b1, -1, 1'b1, "R12 clear at close");
        check_counters("R12 all cleared");

        // R11: saturate the masked counter.
        for (int n = 0; n < SAT + 3; n++)
            do_run(0, 3, -1, 5'd0, -1, 1'b1, -1, 1'b0, "R11 saturate");
        rd_sel = 3'd0; #1;
        chk("R11 held at max", int'(rd_count), SAT);

        // Constrained random runs.
        for (int n = 0; n < 200; n++) begin
            int len = $urandom_range(0, 12);
            int lim = $urandom_range(0, 14);
            int tc  = ($urandom_range(0, 2) == 0) ? -1 : $urandom_range(0, 12);
            int hc  = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 12) : -1;
            logic [4:0] tv = 5'($urandom_range(1, 31));
            bit m = 1'($urandom_range(0, 1));
            do_run(len, lim, tc, tv, hc, m, -1, 1'b0, "R5 R6 R8 random");
        end
        check_counters("R10 final tallies");

        done_flag = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule